// File: doc/BRIEF.md
# Dual-Bus Microcoded Datapath

This block is the register and arithmetic core of a microprogrammed stack machine. It holds nine 32-bit working registers and one 8-bit fetched-byte register. In every clock cycle a microinstruction supplies three control fields. The first is an encoded source selector that places exactly one value on the B bus. The second is an operation code for the ALU, whose left input is always the holding register. The third is a shift code for the shifter that follows the ALU. A destination bitmap then sends the shifter result over the C bus into any number of registers at the next rising clock edge.

The block latches the negative and zero status of the ALU result in the same cycle. The microcode sequencer uses these flags for conditional branches. The fetched byte can enter the B bus in two forms: zero-extended, for unsigned indices, or sign-extended, for signed constants. Two small loading hooks stand in for the memory side. One places a read word into the memory-data register and the other places an instruction byte into the fetched-byte register. The memory controller and the microcode store are outside the block.

Top module: `mbd_datapath`

## Requirements
- R1: `bSel` selects exactly one B bus source. Code 0 is memData, 1 is progCnt, 2 is fetchByte zero-extended, 3 is fetchByte sign-extended, 4 is stackPtr, 5 is localBase, 6 is constBase, 7 is stackTop and 8 is scratch. Codes 9 to 15 drive zero.
- R2: `cWrite` is a destination bitmap. Bit 0 is holdReg, 1 is scratch, 2 is stackTop, 3 is constBase, 4 is localBase, 5 is stackPtr, 6 is progCnt, 7 is memData and 8 is memAddr. Every register whose bit is set takes the same shifter result at the next rising edge, and every register whose bit is clear keeps its value.
- R3: The ALU's left operand is always holdReg (A) and its right operand is the B bus (B). The `aluCtrl` codes are: 0 is A, 1 is B, 2 is A+B, 3 is A+B+1, 4 is B+1, 5 is B-A, 6 is B-1, 7 is -A, 8 is A AND B, 9 is A OR B, 10 is 0, 11 is 1, and 12 is all ones. Codes 13 to 15 give 0.
- R4: At each rising edge flagN takes bit 31 of the ALU result, and flagZ is set exactly when all 32 bits of the ALU result are zero. Both flags are taken before the shifter.
- R5: `shiftCtrl` 0 and 3 pass the ALU result unchanged. Code 1 shifts it left by 8 bits and fills with zeros. Code 2 shifts it right by 1 bit and copies the sign bit into the top.
- R6: When `memLoad` is high, memData takes `memIn` at the rising edge, unless `cWrite` bit 7 is also set, in which case the C bus wins. When `fetchLoad` is high, fetchByte takes `fetchIn`.
- R7: While `rstN` is low, all registers and both flags are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers load on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| bSel | input | 4 | Encoded B bus source |
| cWrite | input | 9 | C bus destination bitmap |
| aluCtrl | input | 4 | ALU operation code |
| shiftCtrl | input | 2 | Shifter operation code |
| memIn | input | 32 | Word returned by a memory read |
| memLoad | input | 1 | Load memIn into memData |
| fetchIn | input | 8 | Instruction byte from the fetch side |
| fetchLoad | input | 1 | Load fetchIn into fetchByte |
| flagN | output | 1 | Latched negative flag of the ALU result |
| flagZ | output | 1 | Latched zero flag of the ALU result |
| memAddr | output | 32 | Memory address register |
| memData | output | 32 | Memory data register |
| progCnt | output | 32 | Program counter |
| fetchByte | output | 8 | Fetched instruction byte |
| stackPtr | output | 32 | Stack pointer |
| localBase | output | 32 | Local frame base |
| constBase | output | 32 | Constant pool base |
| stackTop | output | 32 | Cached top-of-stack word |
| scratch | output | 32 | Scratch register |
| holdReg | output | 32 | Holding register, the ALU left operand |

## Verification
The datapath from the B bus through the ALU and the shifter is purely combinational. Every result therefore shows up one rising edge after the control fields are applied: the written registers and both flags change at that edge and at no other. The bench drives each microinstruction on a falling edge and reads the registers and flags on the next falling edge, which is half a cycle after the commit. The flags are re-latched on every edge, so flag checks are made in that same half-cycle, before the next idle cycle can overwrite them. Values are preloaded through the memory hook. This takes one cycle for the load and one pass-through cycle to copy the value into its destinations.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  parameter int W     = 32;
  parameter int BYTEW = 8;
  parameter int NREG  = 9;
  parameter int NSRC  = 9;
  parameter int SELW  = 4;

  // destination bit positions on the C bus
  parameter int IDX_HOLD  = 0;
  parameter int IDX_SCR   = 1;
  parameter int IDX_TOP   = 2;
  parameter int IDX_CONST = 3;
  parameter int IDX_LOCAL = 4;
  parameter int IDX_SP    = 5;
  parameter int IDX_PC    = 6;
  parameter int IDX_MDATA = 7;
  parameter int IDX_MADDR = 8;

  typedef enum logic [3:0] {
    OP_A      = 4'd0,
    OP_B      = 4'd1,
    OP_ADD    = 4'd2,
    OP_ADDINC = 4'd3,
    OP_INCB   = 4'd4,
    OP_SUB    = 4'd5,
    OP_DECB   = 4'd6,
    OP_NEGA   = 4'd7,
    OP_AND    = 4'd8,
    OP_OR     = 4'd9,
    OP_ZERO   = 4'd10,
    OP_ONE    = 4'd11,
    OP_ONES   = 4'd12,
    OP_R13    = 4'd13,
    OP_R14    = 4'd14,
    OP_R15    = 4'd15
  } aluOpE;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_LL8  = 2'd1,
    SH_AR1  = 2'd2,
    SH_RSV  = 2'd3
  } shiftE;

  typedef struct packed {
    logic [NSRC-1:0] srcHot;
    logic [NREG-1:0] wrMask;
    aluOpE           op;
    shiftE           sh;
  } dpStrobeT;
endpackage

// File: rtl/mbd_ctrl.sv
module mbd_ctrl
  import mbd_pkg::*;
(
  input  logic [SELW-1:0] bSel,
  input  logic [NREG-1:0] cWrite,
  input  logic [3:0]      aluCtrl,
  input  logic [1:0]      shiftCtrl,
  output dpStrobeT        strobe
);
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      strobe.srcHot[i] = (bSel == SELW'(i));
    end
    strobe.wrMask = cWrite;
    strobe.op     = aluOpE'(aluCtrl);
    strobe.sh     = shiftE'(shiftCtrl);
  end
endmodule

// File: rtl/mbd_core.sv
module mbd_core
  import mbd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobeT                 strobe,
  input  logic [W-1:0]             memIn,
  input  logic                     memLoad,
  input  logic [BYTEW-1:0]         fetchIn,
  input  logic                     fetchLoad,
  output logic [NREG-1:0][W-1:0]   regQ,
  output logic [BYTEW-1:0]         fetchQ,
  output logic                     flagN,
  output logic                     flagZ
);
  localparam int EXTW = W - BYTEW;

  logic [NSRC-1:0][W-1:0] srcVal;
  logic [W-1:0] bBus, aluOut, cBus, aOp;

  assign aOp = regQ[IDX_HOLD];

  // B bus candidates in selector-code order
  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      if (s == 0) begin : g_md
        assign srcVal[s] = regQ[IDX_MDATA];
      end else if (s == 1) begin : g_pc
        assign srcVal[s] = regQ[IDX_PC];
      end else if (s == 2) begin : g_zx
        assign srcVal[s] = {{EXTW{1'b0}}, fetchQ};
      end else if (s == 3) begin : g_sx
        assign srcVal[s] = {{EXTW{fetchQ[BYTEW-1]}}, fetchQ};
      end else begin : g_reg
        assign srcVal[s] = regQ[NSRC - s];
      end
    end
  endgenerate

  always_comb begin
    bBus = '0;
    for (int i = 0; i < NSRC; i++) begin
      bBus = bBus | (strobe.srcHot[i] ? srcVal[i] : '0);
    end
  end

  always_comb begin
    case (strobe.op)
      OP_A:      aluOut = aOp;
      OP_B:      aluOut = bBus;
      OP_ADD:    aluOut = aOp + bBus;
      OP_ADDINC: aluOut = aOp + bBus + W'(1);
      OP_INCB:   aluOut = bBus + W'(1);
      OP_SUB:    aluOut = bBus - aOp;
      OP_DECB:   aluOut = bBus - W'(1);
      OP_NEGA:   aluOut = '0 - aOp;
      OP_AND:    aluOut = aOp & bBus;
      OP_OR:     aluOut = aOp | bBus;
      OP_ONE:    aluOut = W'(1);
      OP_ONES:   aluOut = '1;
      default:   aluOut = '0;
    endcase
  end

  always_comb begin
    case (strobe.sh)
      SH_LL8:  cBus = aluOut << 8;
      SH_AR1:  cBus = {aluOut[W-1], aluOut[W-1:1]};
      default: cBus = aluOut;
    endcase
  end

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      if (r == IDX_MDATA) begin : g_mdr
        always_ff @(posedge clk) begin
          if (!rstN)                regQ[r] <= '0;
          else if (strobe.wrMask[r]) regQ[r] <= cBus;
          else if (memLoad)          regQ[r] <= memIn;
        end
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (!rstN)                regQ[r] <= '0;
          else if (strobe.wrMask[r]) regQ[r] <= cBus;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchQ <= '0;
      flagN  <= 1'b0;
      flagZ  <= 1'b0;
    end else begin
      if (fetchLoad) fetchQ <= fetchIn;
      flagN <= aluOut[W-1];
      flagZ <= (aluOut == '0);
    end
  end
endmodule

// File: rtl/mbd_datapath.sv
module mbd_datapath
  import mbd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SELW-1:0]     bSel,
  input  logic [NREG-1:0]     cWrite,
  input  logic [3:0]          aluCtrl,
  input  logic [1:0]          shiftCtrl,
  input  logic [W-1:0]        memIn,
  input  logic                memLoad,
  input  logic [BYTEW-1:0]    fetchIn,
  input  logic                fetchLoad,
  output logic                flagN,
  output logic                flagZ,
  output logic [W-1:0]        memAddr,
  output logic [W-1:0]        memData,
  output logic [W-1:0]        progCnt,
  output logic [BYTEW-1:0]    fetchByte,
  output logic [W-1:0]        stackPtr,
  output logic [W-1:0]        localBase,
  output logic [W-1:0]        constBase,
  output logic [W-1:0]        stackTop,
  output logic [W-1:0]        scratch,
  output logic [W-1:0]        holdReg
);
  dpStrobeT strobe;
  logic [NREG-1:0][W-1:0] regQ;

  mbd_ctrl u_ctrl (
    .bSel(bSel), .cWrite(cWrite), .aluCtrl(aluCtrl),
    .shiftCtrl(shiftCtrl), .strobe(strobe)
  );

  mbd_core u_core (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memIn(memIn),
    .memLoad(memLoad), .fetchIn(fetchIn), .fetchLoad(fetchLoad),
    .regQ(regQ), .fetchQ(fetchByte), .flagN(flagN), .flagZ(flagZ)
  );

  assign holdReg   = regQ[IDX_HOLD];
  assign scratch   = regQ[IDX_SCR];
  assign stackTop  = regQ[IDX_TOP];
  assign constBase = regQ[IDX_CONST];
  assign localBase = regQ[IDX_LOCAL];
  assign stackPtr  = regQ[IDX_SP];
  assign progCnt   = regQ[IDX_PC];
  assign memData   = regQ[IDX_MDATA];
  assign memAddr   = regQ[IDX_MADDR];
endmodule

// File: rtl/mbd_datapath_chk.sv
module mbd_datapath_chk
  import mbd_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic [NSRC-1:0] srcHot,
  input logic [NREG-1:0] cWrite,
  input logic [3:0]      aluCtrl,
  input logic [1:0]      shiftCtrl,
  input logic            flagN,
  input logic            flagZ,
  input logic [W-1:0]    stackTop,
  input logic [W-1:0]    stackPtr,
  input logic [W-1:0]    constBase,
  input logic [W-1:0]    holdReg
);
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcHot)); // R1

  AST_TOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !cWrite[IDX_TOP] |=> $stable(stackTop)); // R2

  AST_CONST_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !cWrite[IDX_CONST] |=> $stable(constBase)); // R2

  AST_SHARED_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (cWrite[IDX_TOP] && cWrite[IDX_SP]) |=> (stackTop == stackPtr)); // R2

  AST_LEFT_IS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cWrite[IDX_TOP] && !cWrite[IDX_HOLD] && aluCtrl == 4'd0 && shiftCtrl == 2'd0)
      |=> (stackTop == $past(holdReg))); // R3

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (cWrite[IDX_TOP] && shiftCtrl == 2'd0) |=> (flagZ == (stackTop == '0))); // R4

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (cWrite[IDX_TOP] && shiftCtrl == 2'd0) |=> (flagN == stackTop[W-1])); // R4
endmodule

bind mbd_datapath mbd_datapath_chk u_chk (
  .clk(clk), .rstN(rstN), .srcHot(strobe.srcHot), .cWrite(cWrite),
  .aluCtrl(aluCtrl), .shiftCtrl(shiftCtrl), .flagN(flagN), .flagZ(flagZ),
  .stackTop(stackTop), .stackPtr(stackPtr), .constBase(constBase),
  .holdReg(holdReg)
);

// File: tb/mbd_datapath_tb.sv
module mbd_datapath_tb;
  import mbd_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] bSel = '0;
  logic [8:0] cWrite = '0;
  logic [3:0] aluCtrl = '0;
  logic [1:0] shiftCtrl = '0;
  logic [31:0] memIn = '0;
  logic memLoad = 1'b0;
  logic [7:0] fetchIn = '0;
  logic fetchLoad = 1'b0;
  logic flagN, flagZ;
  logic [31:0] memAddr, memData, progCnt, stackPtr, localBase, constBase;
  logic [31:0] stackTop, scratch, holdReg;
  logic [7:0] fetchByte;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mbd_datapath u_dut (
    .clk(clk), .rstN(rstN), .bSel(bSel), .cWrite(cWrite), .aluCtrl(aluCtrl),
    .shiftCtrl(shiftCtrl), .memIn(memIn), .memLoad(memLoad), .fetchIn(fetchIn),
    .fetchLoad(fetchLoad), .flagN(flagN), .flagZ(flagZ), .memAddr(memAddr),
    .memData(memData), .progCnt(progCnt), .fetchByte(fetchByte),
    .stackPtr(stackPtr), .localBase(localBase), .constBase(constBase),
    .stackTop(stackTop), .scratch(scratch), .holdReg(holdReg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called on a falling edge; returns on the next falling edge after the commit
  task automatic step(input logic [3:0] b, input aluOpE op, input shiftE sh,
                      input logic [8:0] cw);
    bSel = b; aluCtrl = op; shiftCtrl = sh; cWrite = cw;
    @(negedge clk);
    cWrite = '0; aluCtrl = OP_ZERO; shiftCtrl = SH_NONE; bSel = '0;
  endtask

  task automatic setReg(input logic [8:0] mask, input logic [31:0] val);
    memIn = val; memLoad = 1'b1;
    @(negedge clk);
    memLoad = 1'b0;
    step(4'd0, OP_B, SH_NONE, mask);
  endtask

  function automatic logic [31:0] readOf(input int code);
    case (code)
      0: return memData;
      1: return progCnt;
      4: return stackPtr;
      5: return localBase;
      6: return constBase;
      7: return stackTop;
      default: return scratch;
    endcase
  endfunction

  task automatic testReset();
    chk("R7 stackTop", stackTop, 32'h0);
    chk("R7 holdReg", holdReg, 32'h0);
    chk("R7 memAddr", memAddr, 32'h0);
    chk("R7 fetchByte", {24'h0, fetchByte}, 32'h0);
    chk("R7 flags", {30'h0, flagN, flagZ}, 32'h0);
  endtask

  task automatic testSources();
    int codes[6] = '{0, 1, 4, 5, 6, 7};
    int bits[6]  = '{7, 6, 5, 4, 3, 2};
    for (int k = 0; k < 6; k++) begin
      setReg(9'(1 << bits[k]), 32'h1000_0000 + 32'(k * 17 + 3));
    end
    for (int k = 0; k < 6; k++) begin
      logic [31:0] want;
      want = readOf(codes[k]);
      step(4'(codes[k]), OP_B, SH_NONE, 9'b0_0000_0010);
      chk("R1 source code", scratch, want);
    end
    setReg(9'b0_0000_0010, 32'hCAFE_0008);
    step(4'd8, OP_B, SH_NONE, 9'b0_0000_0100);
    chk("R1 code 8 scratch", stackTop, 32'hCAFE_0008);
    for (int c = 9; c < 16; c++) begin
      setReg(9'b0_0000_0010, 32'hFFFF_FFFF);
      step(4'(c), OP_B, SH_NONE, 9'b0_0000_0010);
      chk("R1 unmapped drives zero", scratch, 32'h0);
    end
  endtask

  task automatic testByte();
    fetchIn = 8'hA5; fetchLoad = 1'b1;
    @(negedge clk);
    fetchLoad = 1'b0;
    chk("R6 fetch load", {24'h0, fetchByte}, 32'h0000_00A5);
    step(4'd2, OP_B, SH_NONE, 9'b0_0000_0010);
    chk("R1 zero extend", scratch, 32'h0000_00A5);
    step(4'd3, OP_B, SH_NONE, 9'b0_0000_0010);
    chk("R1 sign extend neg", scratch, 32'hFFFF_FFA5);
    fetchIn = 8'h5A; fetchLoad = 1'b1;
    @(negedge clk);
    fetchLoad = 1'b0;
    step(4'd3, OP_B, SH_NONE, 9'b0_0000_0010);
    chk("R1 sign extend pos", scratch, 32'h0000_005A);
  endtask

  task automatic testMultiWrite();
    setReg(9'b0_0000_1000, 32'h0BAD_F00D);
    setReg(9'b0_0000_0001, 32'h0000_0100);
    setReg(9'b1_0000_0000, 32'h0000_0033);
    setReg(9'b0_1000_0000, 32'h0000_0020);
    step(4'd0, OP_ADD, SH_NONE, 9'b0_0011_0100);
    chk("R2 multi stackTop", stackTop, 32'h0000_0120);
    chk("R2 multi stackPtr", stackPtr, 32'h0000_0120);
    chk("R2 multi localBase", localBase, 32'h0000_0120);
    chk("R2 unwritten constBase", constBase, 32'h0BAD_F00D);
    chk("R2 unwritten holdReg", holdReg, 32'h0000_0100);
    chk("R2 unwritten memAddr", memAddr, 32'h0000_0033);
    memIn = 32'h7777_7777; memLoad = 1'b1;
    step(4'd7, OP_B, SH_NONE, 9'b0_1000_0000);
    memLoad = 1'b0;
    chk("R6 C bus beats memory load", memData, 32'h0000_0120);
  endtask

  task automatic testAlu();
    setReg(9'b0_0000_0001, 32'd10);
    setReg(9'b0_1000_0000, 32'd3);
    step(4'd0, OP_SUB, SH_NONE, 9'b0_0000_0100);
    chk("R3 B minus H", stackTop, 32'hFFFF_FFF9);
    chk("R4 negative flags", {30'h0, flagN, flagZ}, 32'h2);
    setReg(9'b0_1000_0000, 32'd10);
    step(4'd0, OP_SUB, SH_NONE, 9'b0_0000_0100);
    chk("R3 equal subtract", stackTop, 32'h0);
    chk("R4 zero flags", {30'h0, flagN, flagZ}, 32'h1);
    step(4'd0, OP_ADDINC, SH_NONE, 9'b0_0000_0100);
    chk("R3 add plus one", stackTop, 32'd21);
    chk("R4 positive flags", {30'h0, flagN, flagZ}, 32'h0);
    step(4'd0, OP_INCB, SH_NONE, 9'b0_0000_0100);
    chk("R3 B plus one", stackTop, 32'd11);
    step(4'd0, OP_DECB, SH_NONE, 9'b0_0000_0100);
    chk("R3 B minus one", stackTop, 32'd9);
    step(4'd0, OP_NEGA, SH_NONE, 9'b0_0000_0100);
    chk("R3 negate H", stackTop, 32'hFFFF_FFF6);
    step(4'd0, OP_A, SH_NONE, 9'b0_0000_0100);
    chk("R3 pass H", stackTop, 32'd10);
    setReg(9'b0_1000_0000, 32'h0000_00F3);
    step(4'd0, OP_AND, SH_NONE, 9'b0_0000_0100);
    chk("R3 and", stackTop, 32'h0000_0002);
    step(4'd0, OP_OR, SH_NONE, 9'b0_0000_0100);
    chk("R3 or", stackTop, 32'h0000_00FB);
    step(4'd0, OP_ONE, SH_NONE, 9'b0_0000_0100);
    chk("R3 constant one", stackTop, 32'd1);
    step(4'd0, OP_ONES, SH_NONE, 9'b0_0000_0100);
    chk("R3 all ones", stackTop, 32'hFFFF_FFFF);
    step(4'd0, OP_R14, SH_NONE, 9'b0_0000_0100);
    chk("R3 unused code zero", stackTop, 32'h0);
  endtask

  task automatic testShift();
    setReg(9'b0_1000_0000, 32'h1234_5678);
    step(4'd0, OP_B, SH_LL8, 9'b0_0000_0100);
    chk("R5 left 8", stackTop, 32'h3456_7800);
    setReg(9'b0_1000_0000, 32'h8000_0010);
    step(4'd0, OP_B, SH_AR1, 9'b0_0000_0100);
    chk("R5 arith right neg", stackTop, 32'hC000_0008);
    setReg(9'b0_1000_0000, 32'h4000_0010);
    step(4'd0, OP_B, SH_AR1, 9'b0_0000_0100);
    chk("R5 arith right pos", stackTop, 32'h2000_0008);
    step(4'd0, OP_B, SH_RSV, 9'b0_0000_0100);
    chk("R5 code 3 passes", stackTop, 32'h4000_0010);
    setReg(9'b0_1000_0000, 32'h0100_0000);
    step(4'd0, OP_B, SH_LL8, 9'b0_0000_0100);
    chk("R5 shifted out", stackTop, 32'h0);
    chk("R4 flags before shift", {30'h0, flagN, flagZ}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testSources();
    testByte();
    testMultiWrite();
    testAlu();
    testShift();
    setReg(9'b0_0000_0100, 32'h5555_5555);
    rstN = 1'b0;
    @(negedge clk);
    chk("R7 reset clears", stackTop, 32'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule